// File: doc/BRIEF.md
# PWM Time-Base Counter

This block is the timing core of a pulse-width modulator. A 16-bit counter steps once per prescaled tick and produces the reference count that compare and output-action logic use further down the chip. The tick rate comes from two cascaded dividers. The first divides by a power of two. The second divides by one, or by an even number between 2 and 14. A clock-enable input gates all progress. When it is low, the dividers and the counter hold their state.

Software writes a control word and a period value through two write strobes. The control word selects one of four count modes: up, down, up-down, or frozen. It also selects whether a period write takes effect at once or waits in a shadow register until the next tick at a zero count. The block emits single-cycle zero-match and period-match pulses and a direction flag.

Top module: `pwm_timebase`

## Requirements
- R1: While reset is held, the count is 0 and the direction flag is 0. The control state resets to up mode, shadowed period load and a divide of 1. The active period resets to 0xFFFF.
- R2: The fields of the control word are decoded as follows. Bits 1:0 select the mode: 00 up, 01 down, 10 up-down, 11 freeze. Bit 3 set selects immediate period load. Bits 12:10 hold the power-of-two divider exponent and bits 9:7 hold the even divider field. Bits 15:13, 6:4 and 2 have no effect.
- R3: The tick divide is 2^E × (H ? 2H : 1), where E is the exponent field and H is the even divider field. With the enable held high, the counter advances once every divide cycles, and at no other time.
- R4: While the clock-enable is low, the count, the dividers and the events all hold. Progress resumes from the same point once the enable returns high.
- R5: In up mode, the count steps 0, 1, …, P and then returns to 0, where P is the active period. A count above P goes to 0 on the next tick.
- R6: In down mode, the count decrements on each tick. A tick at 0 reloads P.
- R7: In up-down mode, the count rises to P and falls to 0 without repeating either end value. The direction flag is 1 from the count P down to the count 1, and is 0 on the way up.
- R8: In freeze mode, ticks leave the count unchanged and no event pulses appear.
- R9: When the load bit is clear, a period write goes only to the shadow register. The active period takes the shadow value at the next tick where the count is 0.
- R10: When the load bit is set, a period write sets the active period on the next clock edge. Counting uses the new value from then on.
- R11: In any mode other than freeze, the zero event is high exactly on tick cycles whose count is 0. The period event is high exactly on tick cycles whose count equals the active period.
- R12: Every control-word write clears both divider stages. The next tick follows a full period of the new divide.
- R13: The direction flag is 0 in up mode and 1 in down mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_en | input | 1 | Clock-enable; gates dividers and counter |
| cfg_we | input | 1 | Control-word write strobe |
| cfg_wdata | input | 16 | Control word (mode, load bit, divider fields) |
| prd_we | input | 1 | Period write strobe |
| prd_wdata | input | 16 | Period value |
| count | output | 16 | Current counter value |
| zero_evt | output | 1 | Pulse on a tick with count 0 |
| prd_evt | output | 1 | Pulse on a tick with count equal to the active period |
| dir_down | output | 1 | 1 while counting down |

## Verification
A wrong divider state shows up as a count that steps at the wrong cycle. This is visible within one divide period, and at worst within 16 periods when a stale second-stage value must wrap. A wrong active period, or a shadow load taken at the wrong time, shows up at the next wrap or turn of the count. That is at most P+1 ticks later, through the count value and the period event. A wrong direction state in up-down mode shows up at the flag on the same cycle, and the count moves the wrong way on the following tick.

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CW = 16,
  parameter int DW = 3,
  parameter logic [CW-1:0] RST_PERIOD = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_en,
  input  logic          cfg_we,
  input  logic [15:0]   cfg_wdata,
  input  logic          prd_we,
  input  logic [CW-1:0] prd_wdata,
  output logic [CW-1:0] count,
  output logic          zero_evt,
  output logic          prd_evt,
  output logic          dir_down
);
  localparam int P1W = (1 << DW) - 1;
  localparam int P2W = DW + 1;
  localparam int LOAD_BIT = 3;
  localparam int HS_LO = 7;
  localparam int DIV_LO = 10;
  localparam logic [CW-1:0] ONE = CW'(1);

  typedef enum logic [1:0] {M_UP = 2'd0, M_DOWN = 2'd1, M_UPDN = 2'd2, M_HOLD = 2'd3} mode_t;

  mode_t          mode_q;
  logic           imm_q;
  logic [DW-1:0]  div_q, hs_q;
  logic [P1W-1:0] c1_q, lim1;
  logic [P2W-1:0] c2_q, lim2;
  logic [CW-1:0]  cnt_q, prd_act_q, prd_shd_q;
  logic           dn_q;
  logic           s1_done, tick, live;
  logic           unused_cfg;

  assign unused_cfg = ^{cfg_wdata[15:DIV_LO+DW], cfg_wdata[HS_LO-1:LOAD_BIT+1], cfg_wdata[2]};

  // control word
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= M_UP;
      imm_q  <= 1'b0;
      div_q  <= '0;
      hs_q   <= '0;
    end else if (cfg_we) begin
      mode_q <= mode_t'(cfg_wdata[1:0]);
      imm_q  <= cfg_wdata[LOAD_BIT];
      div_q  <= cfg_wdata[DIV_LO +: DW];
      hs_q   <= cfg_wdata[HS_LO +: DW];
    end
  end

  // two cascaded divider stages
  assign lim1    = ~({P1W{1'b1}} << div_q);
  assign lim2    = (hs_q == '0) ? '0 : ({1'b0, hs_q, 1'b0} - P2W'(1));
  assign s1_done = (c1_q == lim1);
  assign tick    = clk_en && s1_done && (c2_q == lim2);

  always_ff @(posedge clk) begin
    if (!rst_n || cfg_we) begin
      c1_q <= '0;
      c2_q <= '0;
    end else if (clk_en) begin
      if (s1_done) begin
        c1_q <= '0;
        c2_q <= (c2_q == lim2) ? '0 : c2_q + P2W'(1);
      end else begin
        c1_q <= c1_q + P1W'(1);
      end
    end
  end

  // counter and direction
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dn_q  <= 1'b0;
    end else if (tick) begin
      unique case (mode_q)
        M_UP: begin
          cnt_q <= (cnt_q >= prd_act_q) ? '0 : cnt_q + ONE;
          dn_q  <= 1'b0;
        end
        M_DOWN: begin
          cnt_q <= (cnt_q == '0) ? prd_act_q : cnt_q - ONE;
          dn_q  <= 1'b1;
        end
        M_UPDN: begin
          if (!dn_q) begin
            if (cnt_q >= prd_act_q) begin
              cnt_q <= (cnt_q == '0) ? '0 : cnt_q - ONE;
              dn_q  <= 1'b1;
            end else begin
              cnt_q <= cnt_q + ONE;
              dn_q  <= ((cnt_q + ONE) == prd_act_q);
            end
          end else begin
            if (cnt_q == '0) begin
              cnt_q <= (prd_act_q == '0) ? '0 : ONE;
              dn_q  <= (prd_act_q <= ONE);
            end else begin
              cnt_q <= cnt_q - ONE;
              dn_q  <= (cnt_q != ONE);
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign live = tick && (mode_q != M_HOLD);

  // period shadow and active registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prd_act_q <= RST_PERIOD;
      prd_shd_q <= RST_PERIOD;
    end else begin
      if (prd_we) prd_shd_q <= prd_wdata;
      if (prd_we && imm_q) prd_act_q <= prd_wdata;
      else if (live && !imm_q && cnt_q == '0) prd_act_q <= prd_shd_q;
    end
  end

  assign count    = cnt_q;
  assign zero_evt = live && (cnt_q == '0);
  assign prd_evt  = live && (cnt_q == prd_act_q);
  assign dir_down = (mode_q == M_UP) ? 1'b0 : (mode_q == M_DOWN) ? 1'b1 : dn_q;
endmodule

module pwm_timebase_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clk_en,
  input logic          tick,
  input logic [1:0]    mode,
  input logic          imm,
  input logic          prd_we,
  input logic [CW-1:0] prd_wdata,
  input logic [CW-1:0] prd_act,
  input logic [CW-1:0] count,
  input logic          zero_evt,
  input logic          prd_evt
);
  a_r4_hold_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> $stable(count));
  a_r3_moves_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count));
  a_r5_up_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == 2'd0 && count < prd_act) |=> (count == $past(count) + CW'(1)));
  a_r6_down_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == 2'd1 && count == '0) |=> (count == $past(prd_act)));
  a_r8_freeze_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3) |-> (!zero_evt && !prd_evt));
  a_r10_imm_load: assert property (@(posedge clk) disable iff (!rst_n)
    (prd_we && imm) |=> (prd_act == $past(prd_wdata)));
  a_r11_zero_match: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |-> (tick && count == '0));
  a_r11_prd_match: assert property (@(posedge clk) disable iff (!rst_n)
    prd_evt |-> (tick && count == prd_act));
endmodule

bind pwm_timebase pwm_timebase_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .tick(tick), .mode(mode_q),
  .imm(imm_q), .prd_we(prd_we), .prd_wdata(prd_wdata), .prd_act(prd_act_q),
  .count(cnt_q), .zero_evt(zero_evt), .prd_evt(prd_evt)
);

// File: tb/pwm_timebase_tb.sv
module pwm_timebase_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, clk_en, cfg_we, prd_we;
  logic [15:0] cfg_wdata, prd_wdata, count;
  logic        zero_evt, prd_evt, dir_down;
  int          total = 0;
  int          bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_timebase u_dut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .prd_we(prd_we), .prd_wdata(prd_wdata), .count(count), .zero_evt(zero_evt),
    .prd_evt(prd_evt), .dir_down(dir_down)
  );

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int exp_cnt(int mode, int t, int p);
    int m;
    case (mode)
      0: return t % (p + 1);
      1: return (t == 0) ? 0 : p - ((t - 1) % (p + 1));
      2: begin m = t % (2 * p); return (m <= p) ? m : 2 * p - m; end
      default: return 0;
    endcase
  endfunction

  function automatic int exp_dir(int mode, int t, int p);
    case (mode)
      1: return 1;
      2: return ((t % (2 * p)) >= p) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; clk_en = 1'b0; cfg_we = 1'b0; prd_we = 1'b0;
    cfg_wdata = '0; prd_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr_cfg(int v);
    cfg_we = 1'b1; cfg_wdata = 16'(v);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wr_prd(int v);
    prd_we = 1'b1; prd_wdata = 16'(v);
    @(negedge clk);
    prd_we = 1'b0;
  endtask

  // configures with immediate load, then runs n enabled cycles against the formulas
  task automatic run_seq(string req, int ctrl, int p, int d, int n);
    int mode;
    mode = ctrl & 3;
    do_reset();
    wr_cfg(ctrl | 8);
    wr_prd(p);
    clk_en = 1'b1;
    for (int j = 1; j <= n; j++) begin
      int t, c;
      bit tk;
      @(negedge clk);
      t  = j / d;
      c  = exp_cnt(mode, t, p);
      tk = ((j % d) == d - 1);
      check(req, "count", int'(count), c);
      check(req, "dir_down", int'(dir_down), exp_dir(mode, t, p));
      check(req, "zero_evt", int'(zero_evt), int'(tk && mode != 3 && c == 0));
      check(req, "prd_evt", int'(prd_evt), int'(tk && mode != 3 && c == p));
    end
    clk_en = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0; clk_en = 1'b0; cfg_we = 1'b0; prd_we = 1'b0;
    cfg_wdata = '0; prd_wdata = '0;
    repeat (2) @(negedge clk);
    check("R1", "count in reset", int'(count), 0);
    check("R1", "dir in reset", int'(dir_down), 0);
    check("R1", "zero_evt in reset", int'(zero_evt), 0);
    rst_n = 1'b1;
    clk_en = 1'b1;
    for (int j = 1; j <= 3; j++) begin
      @(negedge clk);
      check("R1", "count default divide 1", int'(count), j);
    end
    clk_en = 1'b0;
  endtask

  task automatic t_shadow();
    int exp_list [11] = '{1, 2, 3, 0, 1, 2, 3, 4, 5, 6, 0};
    do_reset();
    wr_cfg(16'h0008);
    wr_prd(3);
    wr_cfg(16'h0000);
    clk_en = 1'b1;
    for (int j = 1; j <= 11; j++) begin
      @(negedge clk);
      check("R9", "count with shadowed period", int'(count), exp_list[j-1]);
      if (j == 1) begin prd_we = 1'b1; prd_wdata = 16'd6; end
      if (j == 2) prd_we = 1'b0;
    end
    clk_en = 1'b0;
  endtask

  task automatic t_immediate();
    int exp_list [5] = '{6, 0, 1, 2, 0};
    do_reset();
    wr_cfg(16'h0008);
    wr_prd(9);
    clk_en = 1'b1;
    for (int j = 1; j <= 10; j++) begin
      @(negedge clk);
      if (j >= 6) check("R10", "count after immediate period write", int'(count), exp_list[j-6]);
      if (j == 9) check("R10", "prd_evt at new period", int'(prd_evt), 1);
      if (j == 5) begin prd_we = 1'b1; prd_wdata = 16'd2; end
      if (j == 6) prd_we = 1'b0;
    end
    clk_en = 1'b0;
  endtask

  task automatic t_enable();
    do_reset();
    wr_cfg(16'h0008);
    wr_prd(20);
    clk_en = 1'b1;
    repeat (4) @(negedge clk);
    check("R4", "count before gating", int'(count), 4);
    clk_en = 1'b0;
    for (int j = 0; j < 5; j++) begin
      @(negedge clk);
      check("R4", "count held while disabled", int'(count), 4);
      check("R4", "no event while disabled", int'(zero_evt | prd_evt), 0);
    end
    clk_en = 1'b1;
    @(negedge clk);
    check("R4", "count resumes", int'(count), 5);
    clk_en = 1'b0;
  endtask

  task automatic t_restart();
    do_reset();
    wr_cfg(16'h0508);
    wr_prd(100);
    clk_en = 1'b1;
    for (int j = 1; j <= 12; j++) begin
      @(negedge clk);
      if (j <= 5) check("R12", "count before rewrite", int'(count), 0);
      if (j >= 6) check("R12", "count after divider restart", int'(count), (j - 6) / 2);
      if (j == 5) begin cfg_we = 1'b1; cfg_wdata = 16'h0408; end
      if (j == 6) cfg_we = 1'b0;
    end
    clk_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    run_seq("R5", 16'h0000, 4, 1, 12);
    run_seq("R6", 16'h0001, 3, 1, 10);
    run_seq("R13", 16'h0001, 5, 1, 3);
    run_seq("R7", 16'h0002, 3, 1, 14);
    run_seq("R8", 16'h0003, 3, 1, 6);
    run_seq("R3", 16'h0500, 5, 8, 60);
    run_seq("R3", 16'h0180, 2, 6, 30);
    run_seq("R11", 16'h0880, 3, 8, 40);
    run_seq("R2", 16'hE075, 4, 1, 12);
    t_shadow();
    t_immediate();
    t_enable();
    t_restart();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule